// File: doc/BRIEF.md
# Real-Time Clock Register Port with Alarm and Interrupt Flags

This block is the software-facing side of a PC-style real-time clock. A pair of byte ports gives access to 128 byte registers. A write to the even port picks a register number, and the odd port then reads or writes that register. The low registers hold the time of day, the date and three alarm bytes. Four status registers control the clock. The first reports an update window and holds the oscillator control field. The second holds the enables and the number formats. The third collects event flags and is cleared when it is read. The fourth is a fixed read-only byte. The rest of the space is plain storage.

The time counter and the frequency divider sit outside this block. They supply a once-per-second tick, a 32768 Hz enable, a periodic-event pulse, and the current time as binary numbers. The block passes the second tick on to the counter only while the oscillator field selects normal running. It then opens an update window of a fixed number of 32768 Hz ticks. When the window closes, the block copies the time into the registers in the selected format (BCD or binary, 12- or 24-hour) and checks the alarm. It also raises the update-ended flag and drives the interrupt line for any flag whose enable is on.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even port (port_odd=0) stores wdata[6:0] as the register index, and bit 7 is dropped. A read from the even port returns 0xFF.
- R2: The alarm bytes (indices 1, 3, 5) and the storage indices 14 to 127 read back the last value written. Index 13 reads 0x80 and keeps that value after a write.
- R3: Bit 7 of index 10 (the update-window flag) cannot be written. A write to index 10 changes bits 6:0 only.
- R4: When index 11 is written with bit 7 (set mode) at 1, bit 4 (update-ended enable) is stored as 0 and the update-window flag is cleared.
- R5: After reset, indices 10, 11, 12 and 13 read 0x26, 0x02, 0x00 and 0x80, and irq is low.
- R6: The second tick is forwarded on time_adv and starts an update only while bits 6:4 of index 10 equal 010. Otherwise time_adv stays low, the update-window flag stays 0 and no update-ended flag follows.
- R7: An accepted tick raises the update-window flag (index 10 bit 7) on the next cycle, unless set mode is on. The flag clears at the UIP_TICKS-th 32768 Hz tick, and index 12 bit 4 (update ended) is set at that same edge.
- R8: At the end of an update outside set mode, indices 0, 2, 4, 6, 7, 8 and 9 receive seconds, minutes, hours, weekday, day, month and year. Values are packed BCD when index 11 bit 2 is 0 and binary when it is 1. When index 11 bit 1 is 0, the hour is shown as 1 to 12 with bit 7 set for the afternoon (hours 12 to 23), and hour 0 shows as 12.
- R9: While set mode is on, an update leaves the time registers as software wrote them and does not raise the update-window flag.
- R10: At the end of an update, index 12 bit 5 (alarm) is set when each alarm byte equals the newly formatted time byte or has bits 7:6 equal to 11.
- R11: Index 12 bit 7 and the irq output are set when a flag is set while its enable is on: periodic (bit 6) with index 11 bit 6, alarm (bit 5) with bit 5, and update ended (bit 4) with bit 4.
- R12: A read of index 12 returns its value, then clears it to 0x00 and lowers irq on the next cycle.
- R13: A per_pulse cycle sets index 12 bit 6.
- R14: Writes to index 12 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_odd | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle rd_en is high |
| sec_tick | input | 1 | Once-per-second pulse from the divider |
| slow_tick | input | 1 | 32768 Hz enable pulse |
| per_pulse | input | 1 | Periodic-event pulse from the divider |
| cur_sec | input | 6 | Current seconds, binary 0 to 59 |
| cur_min | input | 6 | Current minutes, binary 0 to 59 |
| cur_hour | input | 5 | Current hour, binary 0 to 23 |
| cur_wday | input | 3 | Current weekday, 1 to 7 |
| cur_mday | input | 5 | Current day of month, 1 to 31 |
| cur_mon | input | 4 | Current month, 1 to 12 |
| cur_year | input | 7 | Current year within century, 0 to 99 |
| time_adv | output | 1 | Second tick passed on to the time counter |
| irq | output | 1 | Interrupt request, active high |

## Verification
A vector table drives several times of day through full updates, each under a different format setting. Hours 0, 12, 13 and 23 in both 12-hour encodings separate the noon and midnight mapping from the PM bit. Minutes and seconds above 9 separate BCD packing from binary. Alarm tests use three matching cases: an exact byte match, don't-care codes, and a one-second miss. Each runs with the alarm, update-ended or periodic enables on or off, which shows whether the request bit follows the enables or merely the flags. Set mode and a stopped oscillator are each run through a full window to show that they suppress the copy or the whole update.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int IX_SEC    = 0;
  localparam int IX_ASEC   = 1;
  localparam int IX_MIN    = 2;
  localparam int IX_AMIN   = 3;
  localparam int IX_HOUR   = 4;
  localparam int IX_AHOUR  = 5;
  localparam int IX_WDAY   = 6;
  localparam int IX_MDAY   = 7;
  localparam int IX_MON    = 8;
  localparam int IX_YEAR   = 9;
  localparam int IX_CTLA   = 10;
  localparam int IX_CTLB   = 11;
  localparam int IX_FLAGS  = 12;
  localparam int IX_FIXED  = 13;

  localparam int CB_SET  = 7;
  localparam int CB_PIE  = 6;
  localparam int CB_AIE  = 5;
  localparam int CB_UIE  = 4;
  localparam int CB_BIN  = 2;
  localparam int CB_H24  = 1;

  localparam int FL_REQ  = 7;
  localparam int FL_PER  = 6;
  localparam int FL_ALM  = 5;
  localparam int FL_UPD  = 4;

  localparam logic [7:0] RST_CTLA  = 8'h26;
  localparam logic [7:0] RST_CTLB  = 8'h02;
  localparam logic [7:0] RST_FIXED = 8'h80;

  // binary value to register byte in the chosen number format
  function automatic logic [7:0] fmt_val(input logic [6:0] v, input logic bin);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    if (bin) return {1'b0, v};
    return {tens[3:0], ones[3:0]};
  endfunction

  // hour to register byte, 12-hour form carries the PM flag in bit 7
  function automatic logic [7:0] fmt_hour(input logic [4:0] h, input logic bin,
                                          input logic h24);
    logic [4:0] h12;
    logic [7:0] r;
    if (h24) return fmt_val({2'b00, h}, bin);
    h12 = h % 5'd12;
    if (h12 == 5'd0) h12 = 5'd12;
    r = fmt_val({2'b00, h12}, bin);
    r[7] = (h >= 5'd12);
    return r;
  endfunction

  function automatic logic alarm_field_hit(input logic [7:0] alm, input logic [7:0] cur);
    return (alm[7:6] == 2'b11) || (alm == cur);
  endfunction
endpackage

// File: rtl/rtc_uip_window.sv
module rtc_uip_window #(
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic slow_tick,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  assign done = busy && slow_tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy && slow_tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_time_fmt.sv
module rtc_time_fmt
  import rtc_regport_pkg::*;
(
  input  logic [5:0] sec,
  input  logic [5:0] min,
  input  logic [4:0] hour,
  input  logic [2:0] wday,
  input  logic [4:0] mday,
  input  logic [3:0] mon,
  input  logic [6:0] year,
  input  logic       bin,
  input  logic       h24,
  output logic [7:0] f_sec,
  output logic [7:0] f_min,
  output logic [7:0] f_hour,
  output logic [7:0] f_wday,
  output logic [7:0] f_mday,
  output logic [7:0] f_mon,
  output logic [7:0] f_year
);
  always_comb begin
    f_sec  = fmt_val({1'b0, sec}, bin);
    f_min  = fmt_val({1'b0, min}, bin);
    f_hour = fmt_hour(hour, bin, h24);
    f_wday = fmt_val({4'b0, wday}, bin);
    f_mday = fmt_val({2'b0, mday}, bin);
    f_mon  = fmt_val({3'b0, mon}, bin);
    f_year = fmt_val(year, bin);
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_regport_pkg::*;
(
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  output logic       hit
);
  assign hit = alarm_field_hit(alm_sec, now_sec) &&
               alarm_field_hit(alm_min, now_min) &&
               alarm_field_hit(alm_hour, now_hour);
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int UIP_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_odd,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       sec_tick,
  input  logic       slow_tick,
  input  logic       per_pulse,
  input  logic [5:0] cur_sec,
  input  logic [5:0] cur_min,
  input  logic [4:0] cur_hour,
  input  logic [2:0] cur_wday,
  input  logic [4:0] cur_mday,
  input  logic [3:0] cur_mon,
  input  logic [6:0] cur_year,
  output logic       time_adv,
  output logic       irq
);
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] idx;
  logic             uip_q;

  // named internal events
  logic       wr_data, wr_a, wr_b, rd_c;
  logic       osc_ok, start_upd, upd_done, win_busy, alarm_hit;
  logic [7:0] reg_b, reg_c, flags_nx;
  logic [7:0] f_sec, f_min, f_hour, f_wday, f_mday, f_mon, f_year;

  assign reg_b     = mem[IX_CTLB];
  assign reg_c     = mem[IX_FLAGS];
  assign wr_data   = wr_en && port_odd;
  assign wr_a      = wr_data && (idx == IDX_W'(IX_CTLA));
  assign wr_b      = wr_data && (idx == IDX_W'(IX_CTLB));
  assign rd_c      = rd_en && port_odd && (idx == IDX_W'(IX_FLAGS));
  assign osc_ok    = (mem[IX_CTLA][6:4] == 3'b010);
  assign time_adv  = sec_tick && osc_ok;
  assign start_upd = time_adv && !win_busy;
  assign irq       = reg_c[FL_REQ];

  rtc_uip_window #(.TICKS(UIP_TICKS)) u_win (
    .clk(clk), .rst_n(rst_n), .start(start_upd), .slow_tick(slow_tick),
    .busy(win_busy), .done(upd_done)
  );

  rtc_time_fmt u_fmt (
    .sec(cur_sec), .min(cur_min), .hour(cur_hour), .wday(cur_wday),
    .mday(cur_mday), .mon(cur_mon), .year(cur_year),
    .bin(reg_b[CB_BIN]), .h24(reg_b[CB_H24]),
    .f_sec(f_sec), .f_min(f_min), .f_hour(f_hour), .f_wday(f_wday),
    .f_mday(f_mday), .f_mon(f_mon), .f_year(f_year)
  );

  rtc_alarm_cmp u_alm (
    .alm_sec(mem[IX_ASEC]), .alm_min(mem[IX_AMIN]), .alm_hour(mem[IX_AHOUR]),
    .now_sec(f_sec), .now_min(f_min), .now_hour(f_hour), .hit(alarm_hit)
  );

  // flag register: a read clears first, new events then set bits
  always_comb begin
    flags_nx = rd_c ? 8'h00 : reg_c;
    if (per_pulse) begin
      flags_nx[FL_PER] = 1'b1;
      if (reg_b[CB_PIE]) flags_nx[FL_REQ] = 1'b1;
    end
    if (upd_done) begin
      flags_nx[FL_UPD] = 1'b1;
      if (reg_b[CB_UIE]) flags_nx[FL_REQ] = 1'b1;
      if (alarm_hit) begin
        flags_nx[FL_ALM] = 1'b1;
        if (reg_b[CB_AIE]) flags_nx[FL_REQ] = 1'b1;
      end
    end
  end

  always_comb begin
    if (!port_odd)                       rdata = 8'hFF;
    else if (idx == IDX_W'(IX_CTLA))     rdata = {uip_q, mem[IX_CTLA][6:0]};
    else                                 rdata = mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      uip_q <= 1'b0;
    end else begin
      if (wr_en && !port_odd) idx <= wdata[IDX_W-1:0];
      if ((wr_b && wdata[CB_SET]) || upd_done) uip_q <= 1'b0;
      else if (start_upd && !reg_b[CB_SET])   uip_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      mem[IX_CTLA]  <= RST_CTLA;
      mem[IX_CTLB]  <= RST_CTLB;
      mem[IX_FIXED] <= RST_FIXED;
    end else begin
      mem[IX_FLAGS] <= flags_nx;
      if (upd_done && !reg_b[CB_SET]) begin
        mem[IX_SEC]  <= f_sec;
        mem[IX_MIN]  <= f_min;
        mem[IX_HOUR] <= f_hour;
        mem[IX_WDAY] <= f_wday;
        mem[IX_MDAY] <= f_mday;
        mem[IX_MON]  <= f_mon;
        mem[IX_YEAR] <= f_year;
      end
      if (wr_data) begin
        if (idx == IDX_W'(IX_CTLA))
          mem[IX_CTLA] <= {1'b0, wdata[6:0]};
        else if (idx == IDX_W'(IX_CTLB))
          mem[IX_CTLB] <= wdata[CB_SET] ? (wdata & ~(8'h01 << CB_UIE)) : wdata;
        else if (idx != IDX_W'(IX_FLAGS) && idx != IDX_W'(IX_FIXED))
          mem[idx] <= wdata;
      end
    end
  end
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uip,
  input logic [7:0] reg_b,
  input logic [7:0] reg_c,
  input logic       irq,
  input logic       wr_a,
  input logic       wr_b,
  input logic [7:0] wdata,
  input logic       rd_c,
  input logic       per_pulse,
  input logic       sec_tick,
  input logic       osc_ok,
  input logic       win_busy,
  input logic       start_upd,
  input logic       upd_done
);
  AST_A7_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a && !upd_done && !start_upd |=> uip == $past(uip)); // R3
  AST_SETMODE_DROPS_UIE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b && wdata[7] |=> !reg_b[4] && !uip); // R4
  AST_OSC_STOPPED_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && !osc_ok && !win_busy |=> !win_busy && !uip); // R6
  AST_UIP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !uip && reg_c[4]); // R7
  AST_SETMODE_NO_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    start_upd && reg_b[7] && !uip |=> !uip); // R9
  AST_UIE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done && reg_b[4] |=> irq); // R11
  AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_c && !per_pulse && !upd_done |=> reg_c == 8'h00 && !irq); // R12
  AST_PERIODIC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    per_pulse |=> reg_c[6]); // R13
endmodule

bind rtc_regport rtc_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uip(uip_q), .reg_b(reg_b), .reg_c(reg_c),
  .irq(irq), .wr_a(wr_a), .wr_b(wr_b), .wdata(wdata), .rd_c(rd_c),
  .per_pulse(per_pulse), .sec_tick(sec_tick), .osc_ok(osc_ok),
  .win_busy(win_busy), .start_upd(start_upd), .upd_done(upd_done)
);

// File: tb/test_rtc_regport.sv
`timescale 1ns/1ps
module test_rtc_regport;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_odd = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic sec_tick = 1'b0, slow_tick = 1'b0, per_pulse = 1'b0;
  logic [5:0] cur_sec = 6'd0, cur_min = 6'd0;
  logic [4:0] cur_hour = 5'd0;
  logic [2:0] cur_wday = 3'd3;
  logic [4:0] cur_mday = 5'd31;
  logic [3:0] cur_mon = 4'd12;
  logic [6:0] cur_year = 7'd99;
  logic time_adv, irq;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rtc_regport i_rtc_regport (
    .clk(clk), .rst_n(rst_n), .port_odd(port_odd), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sec_tick(sec_tick), .slow_tick(slow_tick),
    .per_pulse(per_pulse), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_wday(cur_wday), .cur_mday(cur_mday),
    .cur_mon(cur_mon), .cur_year(cur_year), .time_adv(time_adv), .irq(irq)
  );

  // {control B, hour, minute, second, exp hour, exp minute, exp second}
  localparam logic [55:0] VEC [7] = '{
    {8'h02, 8'd23, 8'd59, 8'd58, 8'h23, 8'h59, 8'h58},
    {8'h06, 8'd23, 8'd59, 8'd58, 8'h17, 8'h3B, 8'h3A},
    {8'h00, 8'd0,  8'd5,  8'd9,  8'h12, 8'h05, 8'h09},
    {8'h00, 8'd12, 8'd30, 8'd0,  8'h92, 8'h30, 8'h00},
    {8'h00, 8'd13, 8'd7,  8'd45, 8'h81, 8'h07, 8'h45},
    {8'h04, 8'd23, 8'd0,  8'd1,  8'h8B, 8'h00, 8'h01},
    {8'h04, 8'd11, 8'd10, 8'd10, 8'h0B, 8'h0A, 8'h0A}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic odd, input logic [7:0] d);
    @(negedge clk); port_odd = odd; wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic odd, output logic [7:0] d);
    @(negedge clk); port_odd = odd; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
    bus_wr(1'b0, ix); bus_wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] ix, output logic [7:0] d);
    bus_wr(1'b0, ix); bus_rd(1'b1, d);
  endtask

  // one second update; optionally read index 10 in the middle of the window
  task automatic one_second(input bit mid, input logic [7:0] mid_exp, input string req);
    logic [7:0] v;
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
      if (mid && i == 3) begin
        reg_rd(8'd10, v);
        chk(req, v, mid_exp);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5 reset state
    reg_rd(8'd10, v); chk("R5 A", v, 8'h26);
    reg_rd(8'd11, v); chk("R5 B", v, 8'h02);
    reg_rd(8'd12, v); chk("R5 C", v, 8'h00);
    reg_rd(8'd13, v); chk("R5 D", v, 8'h80);
    chk("R5 irq", {7'b0, irq}, 8'h00);

    // R1 index port
    bus_rd(1'b0, v); chk("R1 even read", v, 8'hFF);
    bus_wr(1'b0, 8'hFF); bus_wr(1'b1, 8'h3C);
    reg_rd(8'h7F, v); chk("R1 index masked", v, 8'h3C);

    // R2 storage, alarm byte and fixed register
    reg_wr(8'h50, 8'h5A); reg_rd(8'h50, v); chk("R2 storage", v, 8'h5A);
    reg_wr(8'd3, 8'h47); reg_rd(8'd3, v); chk("R2 alarm byte", v, 8'h47);
    reg_wr(8'd13, 8'h00); reg_rd(8'd13, v); chk("R2 fixed reg", v, 8'h80);

    // R14 flag register write ignored
    reg_wr(8'd12, 8'hFF); reg_rd(8'd12, v); chk("R14 C write", v, 8'h00);
    chk("R14 irq", {7'b0, irq}, 8'h00);

    // R3 update flag not writable while idle
    reg_wr(8'd10, 8'hA6); reg_rd(8'd10, v); chk("R3 idle", v, 8'h26);

    // R7 window: flag high mid-window, low after; update flag set
    one_second(1'b1, 8'hA6, "R7 mid window");
    reg_rd(8'd10, v); chk("R7 after window", v, 8'h26);
    reg_rd(8'd12, v); chk("R7 update flag", v, 8'h10);

    // R8 format table
    for (int k = 0; k < 7; k++) begin
      reg_wr(8'd11, VEC[k][55:48]);
      cur_hour = VEC[k][44:40]; cur_min = VEC[k][37:32]; cur_sec = VEC[k][29:24];
      one_second(1'b0, 8'h00, "");
      reg_rd(8'd4, v); chk($sformatf("R8 hour vec%0d", k), v, VEC[k][23:16]);
      reg_rd(8'd2, v); chk($sformatf("R8 min vec%0d", k), v, VEC[k][15:8]);
      reg_rd(8'd0, v); chk($sformatf("R8 sec vec%0d", k), v, VEC[k][7:0]);
      if (k == 0) begin
        reg_rd(8'd6, v); chk("R8 wday", v, 8'h03);
        reg_rd(8'd7, v); chk("R8 mday", v, 8'h31);
        reg_rd(8'd8, v); chk("R8 month", v, 8'h12);
        reg_rd(8'd9, v); chk("R8 year", v, 8'h99);
      end
      reg_rd(8'd12, v);
    end

    // R10 / R11 alarm with exact seconds and don't-care minutes, hours
    reg_wr(8'd11, 8'h22);
    reg_wr(8'd1, 8'h30); reg_wr(8'd3, 8'hC5); reg_wr(8'd5, 8'hFF);
    cur_hour = 5'd7; cur_min = 6'd22; cur_sec = 6'd30;
    one_second(1'b0, 8'h00, "");
    chk("R11 alarm irq", {7'b0, irq}, 8'h01);
    reg_rd(8'd12, v); chk("R10 alarm hit", v, 8'hB0);
    chk("R12 irq cleared", {7'b0, irq}, 8'h00);
    reg_rd(8'd12, v); chk("R12 cleared", v, 8'h00);
    cur_sec = 6'd31;
    one_second(1'b0, 8'h00, "");
    reg_rd(8'd12, v); chk("R10 alarm miss", v, 8'h10);
    // alarm flag without enable
    reg_wr(8'd11, 8'h02); cur_sec = 6'd30;
    one_second(1'b0, 8'h00, "");
    chk("R11 no enable irq", {7'b0, irq}, 8'h00);
    reg_rd(8'd12, v); chk("R11 flag only", v, 8'h30);
    // update-ended enable
    reg_wr(8'd11, 8'h12); cur_sec = 6'd31;
    one_second(1'b0, 8'h00, "");
    reg_rd(8'd12, v); chk("R11 update irq", v, 8'h90);

    // R13 periodic flag with and without enable
    reg_wr(8'd11, 8'h42);
    @(negedge clk); per_pulse = 1'b1; @(negedge clk); per_pulse = 1'b0;
    chk("R11 periodic irq", {7'b0, irq}, 8'h01);
    reg_rd(8'd12, v); chk("R13 periodic enabled", v, 8'hC0);
    reg_wr(8'd11, 8'h02);
    @(negedge clk); per_pulse = 1'b1; @(negedge clk); per_pulse = 1'b0;
    reg_rd(8'd12, v); chk("R13 periodic disabled", v, 8'h40);

    // R4 / R9 set mode
    reg_wr(8'd11, 8'h92); reg_rd(8'd11, v); chk("R4 UIE dropped", v, 8'h82);
    reg_wr(8'd0, 8'h11);
    one_second(1'b1, 8'h26, "R9 no window flag");
    reg_rd(8'd0, v); chk("R9 time kept", v, 8'h11);
    reg_rd(8'd12, v); chk("R9 update flag", v, 8'h10);
    // R4 set mode write during an active window clears the flag
    reg_wr(8'd11, 8'h02);
    @(negedge clk); sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
    reg_rd(8'd10, v); chk("R4 window open", v, 8'hA6);
    reg_wr(8'd10, 8'h26); reg_rd(8'd10, v); chk("R3 keep during window", v, 8'hA6);
    reg_wr(8'd11, 8'h82); reg_rd(8'd10, v); chk("R4 window flag cleared", v, 8'h26);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
    end
    reg_wr(8'd11, 8'h02); reg_rd(8'd12, v);

    // R6 oscillator stopped
    reg_wr(8'd10, 8'h06);
    @(negedge clk); sec_tick = 1'b1;
    #1 chk("R6 no advance", {7'b0, time_adv}, 8'h00);
    @(negedge clk); sec_tick = 1'b0;
    reg_rd(8'd10, v); chk("R6 no window", v, 8'h06);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
    end
    reg_rd(8'd12, v); chk("R6 no update flag", v, 8'h00);
    reg_wr(8'd10, 8'h26);
    @(negedge clk); sec_tick = 1'b1;
    #1 chk("R6 advance", {7'b0, time_adv}, 8'h01);
    @(negedge clk); sec_tick = 1'b0;

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule